// File: doc/BRIEF.md
# Byte-Parity RAM with Error Reset Control

This block is a single-port RAM of byte-wide locations that keeps one extra check bit beside each byte. On every write it computes even parity over the byte and stores the nine bits together. On every read it recomputes parity over all nine stored bits and reports a mismatch. The memory array can be inferred as block RAM. A synchronous read returns data one cycle after the read strobe.

A small 8-bit control/status register sits next to the array. It holds a sticky error flag and a mask bit. The mask decides whether a detected mismatch produces a one-cycle reset request for the system reset controller. The flag is set whether or not the mask is set. If software clears the mask while the flag is already set, a deferred request is issued at once.

A test-only input stores the inverted check bit on a write, so that the error paths can be reached on purpose.

Top module: `par_ram_top`

## Requirements
- R1: Each location stores nine bits: a data byte and its check bit. After a write, a read of the same address returns the written byte on `mem_rdata` in the cycle after the cycle in which `mem_re` was sampled.
- R2: The check bit is even parity, the XOR of the eight data bits. A read is a mismatch when the XOR of all nine stored bits is 1. When `tst_bad_par` is high during a write, the inverted check bit is stored instead.
- R3: Register layout: bit 7 is the reset mask, bit 0 is the error flag, and bits 6 to 1 always read 0. `reg_rdata` shows the register one cycle after `reg_sel` and `reg_re` are sampled high. A write needs `reg_sel` and `reg_we` both high.
- R4: A synchronous active-high `rst` clears the register to 0x00. After reset, mismatches therefore produce reset requests.
- R5: A mismatch sets the flag on the clock edge after the read data appears, whatever the mask is.
- R6: The flag stays 1 through later error-free reads. Writing 1 to bit 0 does not change it. Writing 0 to bit 0 clears it.
- R7: With the mask at 0, a mismatch raises `rst_req` for exactly one cycle, on the same edge that sets the flag.
- R8: With the mask at 1, a mismatch raises no `rst_req`.
- R9: A register write that takes the mask from 1 to 0 while the flag is 1 raises `rst_req` for one cycle on that write's edge. The same write with the flag at 0 raises no request.
- R10: When a mismatch and a software write of 0 to the flag reach the same edge, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | input | ADDR_W | Memory address |
| mem_wdata | input | 8 | Memory write data |
| mem_we | input | 1 | Memory write enable |
| mem_re | input | 1 | Memory read enable |
| tst_bad_par | input | 1 | Test only: store the inverted check bit on this write |
| mem_rdata | output | 8 | Read data, one cycle after the read |
| reg_sel | input | 1 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered register read data |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Two functions can land on the same clock edge.

The first collision is between the parity checker setting the flag and a software write clearing it. The bench provokes it by reading a location stored with a bad check bit and placing a register write of 0x80 in the very next cycle. A following register read must show the flag at 1.

The second collision is between a mismatch arriving with the mask at 1 and a write that unmasks in that same edge. The combined event must still give exactly one request pulse.

Sweeps over every byte value at mask 0 confirm that good data never raises a request.

// File: rtl/par_ram_pkg.sv
package par_ram_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = BYTE_W + 1;
  localparam int CTL_W    = 8;
  localparam int MASK_BIT = 7;
  localparam int FLAG_BIT = 0;

  typedef struct packed {
    logic              chk;
    logic [BYTE_W-1:0] data;
  } par_word_t;

  function automatic logic even_chk(input logic [BYTE_W-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/par_ram_store.sv
module par_ram_store
  import par_ram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  input  logic              flip_chk,
  output par_word_t         q,
  output logic              q_valid
);
  localparam int DEPTH = 1 << ADDR_W;

  par_word_t mem [DEPTH];
  par_word_t wword;

  always_comb begin
    wword.data = wdata;
    wword.chk  = even_chk(wdata) ^ flip_chk;
  end

  // Array without reset so that block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wword;
    if (re) q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) q_valid <= 1'b0;
    else     q_valid <= re;
  end
endmodule

// File: rtl/par_ram_check.sv
module par_ram_check
  import par_ram_pkg::*;
(
  input  par_word_t         q,
  input  logic              q_valid,
  output logic [BYTE_W-1:0] rdata,
  output logic              mismatch
);
  always_comb begin
    rdata    = q.data;
    mismatch = q_valid & (^{q.chk, q.data});
  end
endmodule

// File: rtl/par_ram_ctl.sv
module par_ram_ctl
  import par_ram_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mismatch,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [CTL_W-1:0] reg_wdata,
  output logic [CTL_W-1:0] reg_rdata,
  output logic             rst_req
);
  logic mask_q, flag_q, wr_hit, mask_nx, req_nx;

  always_comb begin
    wr_hit  = reg_sel & reg_we;
    mask_nx = wr_hit ? reg_wdata[MASK_BIT] : mask_q;
    req_nx  = (mismatch & ~mask_q) | (mask_q & ~mask_nx & (flag_q | mismatch));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= 1'b0;
      flag_q    <= 1'b0;
      rst_req   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      mask_q  <= mask_nx;
      rst_req <= req_nx;
      if (mismatch)
        flag_q <= 1'b1;
      else if (wr_hit && !reg_wdata[FLAG_BIT])
        flag_q <= 1'b0;
      if (reg_sel && reg_re) begin
        reg_rdata           <= '0;
        reg_rdata[MASK_BIT] <= mask_q;
        reg_rdata[FLAG_BIT] <= flag_q;
      end
    end
  end

  p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> flag_q);
  // R10: set wins even when a clearing write shares the edge
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (mismatch && wr_hit && !reg_wdata[FLAG_BIT]) |=> flag_q);
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_hit && !reg_wdata[FLAG_BIT])) |=> flag_q);
  p_req_unmasked_r7: assert property (@(posedge clk) disable iff (rst)
    (mismatch && !mask_q) |=> rst_req);
  p_no_req_masked_r8: assert property (@(posedge clk) disable iff (rst)
    (mismatch && mask_q && !wr_hit) |=> !rst_req);
  p_unmask_req_r9: assert property (@(posedge clk) disable iff (rst)
    (mask_q && flag_q && wr_hit && !reg_wdata[MASK_BIT]) |=> rst_req);
endmodule

// File: rtl/par_ram_top.sv
module par_ram_top
  import par_ram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_wdata,
  input  logic              mem_we,
  input  logic              mem_re,
  input  logic              tst_bad_par,
  output logic [7:0]        mem_rdata,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              rst_req
);
  par_word_t q;
  logic      q_valid, mismatch;

  par_ram_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .addr(mem_addr), .wdata(mem_wdata),
    .we(mem_we), .re(mem_re), .flip_chk(tst_bad_par),
    .q(q), .q_valid(q_valid)
  );

  par_ram_check u_check (
    .q(q), .q_valid(q_valid), .rdata(mem_rdata), .mismatch(mismatch)
  );

  par_ram_ctl u_ctl (
    .clk(clk), .rst(rst), .mismatch(mismatch),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req)
  );

  // R1: the read strobe always yields a validated word one cycle later
  p_read_latency_r1: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> q_valid);
endmodule

// File: tb/tb_par_ram_top.sv
`timescale 1ns/1ps
module tb_par_ram_top;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0, reg_wdata = '0;
  logic          we = 1'b0, re = 1'b0, bad = 1'b0;
  logic          reg_sel = 1'b0, reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]    rdata, reg_rdata;
  logic          rst_req;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  par_ram_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .mem_addr(addr), .mem_wdata(wdata),
    .mem_we(we), .mem_re(re), .tst_bad_par(bad), .mem_rdata(rdata),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic mwr(input logic [AW-1:0] a, input logic [7:0] d, input bit b);
    @(negedge clk); addr = a; wdata = d; we = 1'b1; bad = b;
    @(negedge clk); we = 1'b0; bad = 1'b0;
  endtask

  task automatic mrd(input logic [AW-1:0] a, output logic [7:0] d, output logic rq);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
    @(negedge clk); rq = rst_req;
  endtask

  task automatic rwr(input logic [7:0] v, output logic rq);
    @(negedge clk); reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_sel = 1'b0; reg_we = 1'b0; rq = rst_req;
  endtask

  task automatic rrd(output logic [7:0] v);
    @(negedge clk); reg_sel = 1'b1; reg_re = 1'b1;
    @(negedge clk); reg_sel = 1'b0; reg_re = 1'b0; v = reg_rdata;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d, v;
    logic rq;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rrd(v); chk(v == 8'h00, "R4 reset value", v, 8'h00);

    // R1 R2: every byte value, good parity, mask 0 -> data back, no request
    for (int i = 0; i < 256; i++) begin
      mwr(AW'(i), 8'(i), 1'b0);
      mrd(AW'(i), d, rq);
      chk(d == 8'(i), "R1 read data", d, i);
      chk(rq == 1'b0, "R2 good parity no request", rq, 0);
    end
    // R1 across all addresses
    for (int i = 0; i < 16; i++) mwr(AW'(i), 8'(i * 37 + 5), 1'b0);
    for (int i = 0; i < 16; i++) begin
      mrd(AW'(i), d, rq);
      chk(d == 8'(i * 37 + 5), "R1 address sweep", d, 8'(i * 37 + 5));
    end
    rrd(v); chk(v == 8'h00, "R5 no flag after good reads", v, 0);

    // R7: mask 0, bad parity -> single pulse, flag set, data intact
    mwr(4'd5, 8'h3C, 1'b1);
    mrd(4'd5, d, rq);
    chk(d == 8'h3C, "R2 bad word data", d, 8'h3C);
    chk(rq == 1'b1, "R7 request on mismatch", rq, 1);
    @(negedge clk); chk(rst_req == 1'b0, "R7 single-cycle pulse", rst_req, 0);
    rrd(v); chk(v == 8'h01, "R5 flag set", v, 8'h01);
    // R6 sticky
    mrd(4'd1, d, rq);
    rrd(v); chk(v == 8'h01, "R6 flag sticky over good read", v, 8'h01);
    rwr(8'h01, rq);
    rrd(v); chk(v == 8'h01, "R6 write 1 no effect", v, 8'h01);
    rwr(8'h00, rq);
    rrd(v); chk(v == 8'h00, "R6 write 0 clears", v, 8'h00);

    // R3 reserved bits
    rwr(8'hFE, rq);
    rrd(v); chk(v == 8'h80, "R3 layout and reserved bits", v, 8'h80);

    // R8 / R5: masked mismatches over several words
    for (int i = 0; i < 16; i++) begin
      mwr(AW'(i), 8'(i * 11), 1'b1);
      mrd(AW'(i), d, rq);
      chk(d == 8'(i * 11), "R2 bad word data masked", d, 8'(i * 11));
      chk(rq == 1'b0, "R8 no request when masked", rq, 0);
    end
    rrd(v); chk(v == 8'h81, "R5 flag set while masked", v, 8'h81);

    // R9: unmask with flag set -> request; flag kept
    rwr(8'h01, rq);
    chk(rq == 1'b1, "R9 unmask with flag", rq, 1);
    @(negedge clk); chk(rst_req == 1'b0, "R9 single pulse", rst_req, 0);
    rrd(v); chk(v == 8'h01, "R9 register after unmask", v, 8'h01);
    // R9 boundary: unmask with flag clear -> nothing
    rwr(8'h80, rq);
    rwr(8'h00, rq);
    chk(rq == 1'b0, "R9 unmask without flag", rq, 0);

    // R10: mismatch and clearing write on the same edge
    rwr(8'h80, rq);
    mwr(4'd7, 8'hA5, 1'b1);
    @(negedge clk); addr = 4'd7; re = 1'b1;
    @(negedge clk); re = 1'b0; reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 8'h80;
    @(negedge clk); reg_sel = 1'b0; reg_we = 1'b0;
    chk(rst_req == 1'b0, "R8 no request in collision", rst_req, 0);
    rrd(v); chk(v == 8'h81, "R10 hardware set wins", v, 8'h81);

    // R4: reset clears a populated register
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(rst_req == 1'b0, "R4 no request after reset", rst_req, 0);
    rrd(v); chk(v == 8'h00, "R4 reset clears register", v, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule